// File: doc/BRIEF.md
# UART Burst FIFO Access Port

This block sits between a host register bus and the two data queues of a UART. The serial side pushes received bytes into a receive queue and pulls bytes to send from a transmit queue. The host reaches both queues through a small set of register offsets. A byte access moves one character. A 32-bit access at a dedicated burst offset moves up to four characters in a single bus cycle, which cuts the number of bus transactions a driver needs per interrupt by about four.

A single status read gives the host everything it needs to service the port. The status word holds the receive fill level, the free transmit space, an active-low "nothing pending" flag, a sticky transmit-overflow flag and eight line-status bits. The receive overrun and transmit overflow flags are sticky. A host clears them by writing a specific control code to the FIFO-control offset. Read data returns one cycle after the request, together with a valid strobe.

The offset map is fixed. 0x00 is single-byte data (a read pops receive, a write pushes transmit). 0x02 is FIFO control. 0x9C is burst status. 0xA0 is burst transmit (write). 0xA4 is burst receive (read). Reads at any other offset return zero. Writes to any other offset have no effect. The queue depth is a power-of-two parameter of at most 128.

Top module: `uart_burst_port`

## Requirements
- R1: After reset, a status read (offset 0x9C) returns receive count 0 in bits 7:0, free transmit entries equal to DEPTH in bits 15:8, bit 29 (transmit empty) set, bit 20 set and all other bits clear.
- R2: A write at offset 0x00 pushes wdata[7:0] into the transmit queue. The serial side then sees it on `tx_byte`, with `tx_avail` high.
- R3: A read at offset 0x00 pops one receive byte into rdata[7:0], with bits 31:8 zero. `host_rvalid` is high in the cycle after the request and only then.
- R4: A read at offset 0xA4 with four or more bytes queued pops four bytes, with the oldest in rdata[7:0] and the newest in rdata[31:24].
- R5: A read at offset 0xA4 with fewer than four bytes queued pops only those bytes and returns zero in the unfilled upper byte lanes.
- R6: A write at offset 0xA0 pushes four bytes, wdata[7:0] first and wdata[31:24] last.
- R7: A write at 0x00 or 0xA0 that asks for more entries than are free pushes only the lower bytes that fit. It sets a sticky overflow flag in status bit 21, which stays set after the queue drains.
- R8: A receive push into a full queue drops the byte and sets the sticky overrun bit 25 and the receive-error bit 31. Writing 0x43 to offset 0x02 clears bits 25 and 21. Writing any other value there clears nothing.
- R9: `irq` is high, and status bit 20 is clear, exactly when the receive queue is non-empty or any of overrun, parity or framing is set. Otherwise bit 20 is set and `irq` is low.
- R10: Status bit 26 follows `line_parity` and bit 27 follows `line_frame`. Bit 31 is set whenever either of them, or overrun, is set.
- R11: A status read issued in the cycle right after a push or pop already shows the updated counts.
- R12: Status bit 24 (data ready) is set exactly when the receive queue is non-empty. Bit 29 is set exactly when the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Register offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| rx_push | input | 1 | Serial side delivers a received byte |
| rx_byte | input | 8 | Received byte |
| line_parity | input | 1 | Parity error reported by the receiver |
| line_frame | input | 1 | Framing error reported by the receiver |
| tx_pop | input | 1 | Serial side takes the head transmit byte |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_avail | output | 1 | Transmit queue non-empty |
| irq | output | 1 | Service request, inverse of status bit 20 |

## Verification
The bench targets partial bursts at both edges. It does a receive burst with only two bytes queued, which a design that popped four would corrupt with stale storage and leave the count wrapped below zero. It also does a transmit burst into two free slots, where a careless design would overwrite the oldest queued bytes or lose the overflow flag once the queue drains. Byte lane order is checked against known sequences, so a design with reversed lanes returns the bytes swapped. Overrun is driven by overfilling the receive queue, then followed by a wrong control code and the right one: a design that clears on any write would drop the flag too early. A status read placed directly behind a pop catches counts that lag by a cycle.

// File: rtl/uart_burst_pkg.sv
package uart_burst_pkg;

    localparam int ADDR_W = 8;
    localparam int LANES  = 4;

    localparam logic [ADDR_W-1:0] OFS_BYTE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_FCTL = 8'h02;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h9C;
    localparam logic [ADDR_W-1:0] OFS_TXW  = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_RXW  = 8'hA4;

    localparam logic [7:0] FLAG_CLEAR_CODE = 8'h43;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_BYTE_RD,
        ACC_BYTE_WR,
        ACC_WORD_RD,
        ACC_WORD_WR,
        ACC_STAT_RD,
        ACC_FCTL_WR
    } acc_kind_e;

    // Upper status byte, bit 7 of this struct lands on status bit 31
    typedef struct packed {
        logic rx_err;
        logic rsv_b30;
        logic tx_empty;
        logic rsv_b28;
        logic frame;
        logic parity;
        logic overrun;
        logic data_ready;
    } line_stat_t;

    function automatic acc_kind_e decode_access(input logic valid,
                                                input logic write,
                                                input logic [ADDR_W-1:0] addr);
        acc_kind_e kind;
        kind = ACC_NONE;
        if (valid) begin
            if (write) begin
                case (addr)
                    OFS_BYTE: kind = ACC_BYTE_WR;
                    OFS_TXW:  kind = ACC_WORD_WR;
                    OFS_FCTL: kind = ACC_FCTL_WR;
                    default:  kind = ACC_NONE;
                endcase
            end else begin
                case (addr)
                    OFS_BYTE: kind = ACC_BYTE_RD;
                    OFS_RXW:  kind = ACC_WORD_RD;
                    OFS_STAT: kind = ACC_STAT_RD;
                    default:  kind = ACC_NONE;
                endcase
            end
        end
        return kind;
    endfunction

endpackage

// File: rtl/ubp_fifo.sv
module ubp_fifo #(
    parameter int DEPTH      = 16,
    parameter int PUSH_LANES = 4,
    parameter int POP_LANES  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(PUSH_LANES+1)-1:0] push_n,
    input  logic [8*PUSH_LANES-1:0]     push_data,
    input  logic [$clog2(POP_LANES+1)-1:0]  pop_n,
    output logic [8*POP_LANES-1:0]      peek_data,
    output logic [$clog2(DEPTH+1)-1:0]  count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_LANES; i++) begin
            if (i < int'(push_n)) mem[wr_ptr + PW'(i)] <= push_data[8*i +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(push_n);
            rd_ptr <= rd_ptr + PW'(pop_n);
            cnt    <= cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    // Show-ahead view of the oldest entries; lanes past the fill level read zero
    generate
        for (genvar g = 0; g < POP_LANES; g++) begin : g_peek
            assign peek_data[8*g +: 8] = (CW'(g) < cnt) ? mem[rd_ptr + PW'(g)] : 8'h00;
        end
    endgenerate

    assign count = cnt;

endmodule

// File: rtl/ubp_line_status.sv
module ubp_line_status
    import uart_burst_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ovr_set,
    input  logic                       ovf_set,
    input  logic                       flag_clear,
    input  logic [$clog2(DEPTH+1)-1:0] rx_count,
    input  logic [$clog2(DEPTH+1)-1:0] tx_count,
    input  logic                       line_parity,
    input  logic                       line_frame,
    output logic [31:0]                status_word,
    output logic                       irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic       overrun_q, tx_ovf_q;
    line_stat_t lsr;
    logic [CW-1:0] tx_free;

    // Set wins over a clear landing in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            overrun_q <= 1'b0;
            tx_ovf_q  <= 1'b0;
        end else begin
            if (ovr_set)         overrun_q <= 1'b1;
            else if (flag_clear) overrun_q <= 1'b0;
            if (ovf_set)         tx_ovf_q  <= 1'b1;
            else if (flag_clear) tx_ovf_q  <= 1'b0;
        end
    end

    always_comb begin
        lsr            = '0;
        lsr.data_ready = (rx_count != '0);
        lsr.overrun    = overrun_q;
        lsr.parity     = line_parity;
        lsr.frame      = line_frame;
        lsr.tx_empty   = (tx_count == '0);
        lsr.rx_err     = overrun_q | line_parity | line_frame;
        tx_free        = CW'(DEPTH) - tx_count;
        irq            = lsr.data_ready | lsr.rx_err;
        status_word    = {lsr, 2'b00, tx_ovf_q, ~irq, 4'h0, 8'(tx_free), 8'(rx_count)};
    end

endmodule

// File: rtl/ubp_host_port.sv
module ubp_host_port
    import uart_burst_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_valid,
    input  logic                       host_write,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [31:0]                host_wdata,
    input  logic [$clog2(DEPTH+1)-1:0] rx_count,
    input  logic [$clog2(DEPTH+1)-1:0] tx_count,
    input  logic [8*LANES-1:0]         rx_peek,
    input  logic [31:0]                status_word,
    output logic [$clog2(LANES+1)-1:0] rx_pop_n,
    output logic [$clog2(LANES+1)-1:0] tx_push_n,
    output logic [8*LANES-1:0]         tx_push_data,
    output logic                       ovf_set,
    output logic                       flag_clear,
    output logic [31:0]                host_rdata,
    output logic                       host_rvalid
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int NW = $clog2(LANES+1);

    acc_kind_e     kind;
    logic [CW-1:0] tx_free;
    logic [NW-1:0] rx_take, tx_take;
    logic [31:0]   rdata_d;
    logic          is_read;

    always_comb begin
        kind    = decode_access(host_valid, host_write, host_addr);
        tx_free = CW'(DEPTH) - tx_count;
        rx_take = (rx_count >= CW'(LANES)) ? NW'(LANES) : NW'(rx_count);
        tx_take = (tx_free  >= CW'(LANES)) ? NW'(LANES) : NW'(tx_free);

        rx_pop_n     = '0;
        tx_push_n    = '0;
        tx_push_data = host_wdata;
        ovf_set      = 1'b0;
        flag_clear   = 1'b0;
        rdata_d      = '0;
        is_read      = 1'b0;

        case (kind)
            ACC_BYTE_RD: begin
                rx_pop_n = (rx_count != '0) ? NW'(1) : '0;
                rdata_d  = {24'h0, rx_peek[7:0]};
                is_read  = 1'b1;
            end
            ACC_WORD_RD: begin
                rx_pop_n = rx_take;
                rdata_d  = rx_peek;
                is_read  = 1'b1;
            end
            ACC_STAT_RD: begin
                rdata_d  = status_word;
                is_read  = 1'b1;
            end
            ACC_BYTE_WR: begin
                tx_push_n    = (tx_free != '0) ? NW'(1) : '0;
                tx_push_data = {24'h0, host_wdata[7:0]};
                ovf_set      = (tx_free == '0);
            end
            ACC_WORD_WR: begin
                tx_push_n = tx_take;
                ovf_set   = (tx_free < CW'(LANES));
            end
            ACC_FCTL_WR: begin
                flag_clear = (host_wdata[7:0] == FLAG_CLEAR_CODE);
            end
            default: begin
                is_read = host_valid & ~host_write;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rdata  <= rdata_d;
            host_rvalid <= is_read;
        end
    end

endmodule

// File: rtl/uart_burst_port.sv
module uart_burst_port
    import uart_burst_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_valid,
    input  logic        host_write,
    input  logic [7:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_rvalid,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    input  logic        line_parity,
    input  logic        line_frame,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    output logic        tx_avail,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int NW = $clog2(LANES+1);

    logic [CW-1:0]      rx_count, tx_count;
    logic [8*LANES-1:0] rx_peek, tx_push_data;
    logic [NW-1:0]      rx_pop_n, tx_push_n;
    logic               rx_push_ok, rx_drop, tx_pop_ok;
    logic               ovf_set, flag_clear;
    logic [31:0]        status_word;

    assign rx_push_ok = rx_push & (rx_count != CW'(DEPTH));
    assign rx_drop    = rx_push & (rx_count == CW'(DEPTH));
    assign tx_pop_ok  = tx_pop & (tx_count != '0);
    assign tx_avail   = (tx_count != '0);

    ubp_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(LANES)) u_rx_q (
        .clk       (clk),
        .rst       (rst),
        .push_n    (rx_push_ok),
        .push_data (rx_byte),
        .pop_n     (rx_pop_n),
        .peek_data (rx_peek),
        .count     (rx_count)
    );

    ubp_fifo #(.DEPTH(DEPTH), .PUSH_LANES(LANES), .POP_LANES(1)) u_tx_q (
        .clk       (clk),
        .rst       (rst),
        .push_n    (tx_push_n),
        .push_data (tx_push_data),
        .pop_n     (tx_pop_ok),
        .peek_data (tx_byte),
        .count     (tx_count)
    );

    ubp_host_port #(.DEPTH(DEPTH)) u_host (
        .clk          (clk),
        .rst          (rst),
        .host_valid   (host_valid),
        .host_write   (host_write),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .rx_count     (rx_count),
        .tx_count     (tx_count),
        .rx_peek      (rx_peek),
        .status_word  (status_word),
        .rx_pop_n     (rx_pop_n),
        .tx_push_n    (tx_push_n),
        .tx_push_data (tx_push_data),
        .ovf_set      (ovf_set),
        .flag_clear   (flag_clear),
        .host_rdata   (host_rdata),
        .host_rvalid  (host_rvalid)
    );

    ubp_line_status #(.DEPTH(DEPTH)) u_stat (
        .clk         (clk),
        .rst         (rst),
        .ovr_set     (rx_drop),
        .ovf_set     (ovf_set),
        .flag_clear  (flag_clear),
        .rx_count    (rx_count),
        .tx_count    (tx_count),
        .line_parity (line_parity),
        .line_frame  (line_frame),
        .status_word (status_word),
        .irq         (irq)
    );

endmodule

// File: rtl/uart_burst_port_checker.sv
module uart_burst_port_checker #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        host_valid,
    input logic        host_write,
    input logic [7:0]  host_addr,
    input logic [31:0] host_rdata,
    input logic        host_rvalid,
    input logic        tx_avail,
    input logic        irq
);
    logic rd_req, stat_req, byte_wr;
    assign rd_req   = host_valid & ~host_write;
    assign stat_req = rd_req & (host_addr == 8'h9C);
    assign byte_wr  = host_valid & host_write & (host_addr == 8'h00);

    // R3: every read gets a strobe in the next cycle
    assert_read_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> host_rvalid);

    // R3: no strobe without a read in the previous cycle
    assert_no_stray_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !host_rvalid);

    // R9: status bit 20 is the inverse of irq at the time of the request
    assert_idle_flag_R9: assert property (@(posedge clk) disable iff (rst)
        stat_req |=> (host_rdata[20] == !$past(irq)));

    // R1: counts never exceed the queue depth
    assert_counts_bounded_R1: assert property (@(posedge clk) disable iff (rst)
        stat_req |=> ((host_rdata[7:0] <= 8'(DEPTH)) && (host_rdata[15:8] <= 8'(DEPTH))));

    // R2: a byte write always leaves something for the serial side
    assert_byte_push_visible_R2: assert property (@(posedge clk) disable iff (rst)
        byte_wr |=> tx_avail);

endmodule

bind uart_burst_port uart_burst_port_checker #(.DEPTH(DEPTH)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_addr   (host_addr),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .tx_avail    (tx_avail),
    .irq         (irq)
);

// File: tb/tb_uart_burst_port.sv
`timescale 1ns/1ps
module tb_uart_burst_port;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_valid, host_write;
    logic [7:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        rx_push;
    logic [7:0]  rx_byte;
    logic        line_parity, line_frame;
    logic        tx_pop;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    uart_burst_port #(.DEPTH(DEPTH)) dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each returned read against the scoreboard
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected rvalid", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic host_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_in(input logic [7:0] b);
        rx_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic tx_take(input logic [7:0] exp, input string tag);
        check({tag, " avail"}, {31'h0, tx_avail}, 32'h1);
        check(tag, {24'h0, tx_byte}, {24'h0, exp});
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        rst = 1'b1; host_valid = 0; host_write = 0; host_addr = 0; host_wdata = 0;
        rx_push = 0; rx_byte = 0; line_parity = 0; line_frame = 0; tx_pop = 0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        host_rd(8'h9C, 32'h2010_1000, "R1 reset status");
        idle(2);
        check("R9 irq idle", {31'h0, irq}, 32'h0);

        // R4/R12/R9 receive five bytes
        rx_in(8'h11); rx_in(8'h22); rx_in(8'h33); rx_in(8'h44); rx_in(8'h55);
        host_rd(8'h9C, 32'h2100_1005, "R12 status data ready");
        idle(1);
        check("R9 irq rx pending", {31'h0, irq}, 32'h1);
        host_rd(8'hA4, 32'h4433_2211, "R4 burst read order");
        host_rd(8'h00, 32'h0000_0055, "R3 byte read");
        host_rd(8'h9C, 32'h2010_1000, "R11 status right after pop");
        idle(2);

        // R5 short burst read
        rx_in(8'hA1); rx_in(8'hB2);
        host_rd(8'hA4, 32'h0000_B2A1, "R5 short burst zero fill");
        host_rd(8'h9C, 32'h2010_1000, "R5 count after short burst");
        host_rd(8'hA4, 32'h0000_0000, "R5 burst read on empty");
        idle(2);

        // R6 burst write
        host_wr(8'hA0, 32'hDDCC_BBAA);
        host_rd(8'h9C, 32'h0010_0C00, "R11 status right after burst write");
        idle(1);
        tx_take(8'hAA, "R6 lane0"); tx_take(8'hBB, "R6 lane1");
        tx_take(8'hCC, "R6 lane2"); tx_take(8'hDD, "R6 lane3");

        // R2 byte write
        host_wr(8'h00, 32'hFFFF_FF5A);
        tx_take(8'h5A, "R2 byte push");
        check("R2 drained", {31'h0, tx_avail}, 32'h0);

        // R7 partial burst write
        host_wr(8'hA0, 32'h0302_0100);
        host_wr(8'hA0, 32'h0706_0504);
        host_wr(8'hA0, 32'h0B0A_0908);
        host_wr(8'h00, 32'h0000_00E1);
        host_wr(8'h00, 32'h0000_00E2);
        host_wr(8'hA0, 32'h4433_2211);
        host_rd(8'h9C, 32'h0030_0000, "R7 full with overflow flag");
        idle(1);
        for (int i = 0; i < 12; i++) tx_take(8'(i), "R7 drain order");
        tx_take(8'hE1, "R7 byte E1"); tx_take(8'hE2, "R7 byte E2");
        tx_take(8'h11, "R7 fitted lane0"); tx_take(8'h22, "R7 fitted lane1");
        check("R7 nothing beyond fit", {31'h0, tx_avail}, 32'h0);
        host_rd(8'h9C, 32'h2030_1000, "R7 overflow sticky");
        host_wr(8'h02, 32'h0000_0043);
        host_rd(8'h9C, 32'h2010_1000, "R8 clear code clears overflow");
        idle(2);

        // R8 overrun
        for (int i = 0; i < 17; i++) rx_in(8'(i));
        host_rd(8'h9C, 32'hA300_1010, "R8 overrun set");
        host_wr(8'h02, 32'h0000_0042);
        host_rd(8'h9C, 32'hA300_1010, "R8 wrong code ignored");
        host_wr(8'h02, 32'h0000_0043);
        host_rd(8'h9C, 32'h2100_1010, "R8 overrun cleared");
        host_rd(8'hA4, 32'h0302_0100, "R4 burst 0");
        host_rd(8'hA4, 32'h0706_0504, "R4 burst 1");
        host_rd(8'hA4, 32'h0B0A_0908, "R4 burst 2");
        host_rd(8'hA4, 32'h0F0E_0D0C, "R8 dropped byte absent");
        host_rd(8'h9C, 32'h2010_1000, "R12 empty again");
        idle(2);

        // R10 line errors
        line_parity = 1'b1;
        host_rd(8'h9C, 32'hA400_1000, "R10 parity");
        idle(1);
        check("R9 irq on parity", {31'h0, irq}, 32'h1);
        line_parity = 1'b0; line_frame = 1'b1;
        host_rd(8'h9C, 32'hA800_1000, "R10 frame");
        line_frame = 1'b0;
        host_rd(8'h9C, 32'h2010_1000, "R10 errors gone");
        idle(1);
        check("R9 irq released", {31'h0, irq}, 32'h0);

        idle(4);
        check("R3 all reads answered", exp_q.size(), 32'h0);
        summary();
    end

endmodule